// File: doc/BRIEF.md
# Data Space Router with CPU-Owned I/O Registers

This block sits between a small processor core's load/store unit and the rest of the data path. It takes one byte request at a time on a flat data address space and decides where it lands. The lowest addresses reach a local file of general registers. The next window is the I/O region. Everything above that goes out to data memory. A request can also be marked as a port access, in which case its address is taken directly as an I/O port number, counted from the start of the I/O region.

Eight ports at the top of the I/O region are owned by the core and held locally. They are four extended address page registers, an extended indirect-jump register, the two halves of the stack pointer, and the status register. The page and jump registers keep their byte already moved up into bits 23:16, so a consumer can OR them straight into a 24-bit address. Feature inputs decide whether the optional page registers and the stack pointer high byte accept writes. Every other I/O port is passed to the external memory interface at the address of the I/O region base plus the port number.

Internal targets answer in the same cycle. External accesses follow a valid/ready handshake, and the memory's ready and read data are passed back unchanged.

Top module: `data_space_router`

## Requirements
- R1: A data access (req_port=0) with address below 0x20 selects general register [address]. The read data returns in the same cycle with req_ready=1, and mem_valid stays 0.
- R2: A data access with address 0x20..0x5F selects I/O port (address − 0x20). A port access (req_port=1) uses req_addr[5:0] as the port number.
- R3: A data access with address 0x60 or above drives mem_valid=req_valid and mem_addr=req_addr. req_ready follows mem_ready and req_rdata follows mem_rdata.
- R4: An I/O port below 0x38 goes to external memory: mem_valid=1, mem_addr=0x20+port, and mem_we and mem_wdata are taken from the request.
- R5: Ports 0x38, 0x39, 0x3A and 0x3B are page registers 0 to 3, shown on page_o[0..3]. A write stores the byte in bits 23:16 with zeros below, and a read returns bits 23:16.
- R6: A write to page register i takes effect only when feat_page[i]=1. Otherwise the register is left unchanged.
- R7: Port 0x3C is the extended indirect-jump register (eind_o). It always accepts writes, stores the byte in bits 23:16, and reads back bits 23:16.
- R8: A write to port 0x3D replaces sp_o[7:0] and keeps sp_o[15:8].
- R9: A write to port 0x3E replaces sp_o[15:8] only when feat_wide_sp=1. Otherwise sp_o is unchanged. A read of 0x3E returns sp_o[15:8].
- R10: Port 0x3F is the 8-bit status register on sreg_o. It reads back exactly what was written.
- R11: After reset all local registers and general registers read zero.
- R12: Accesses to local ports never raise mem_valid and always see req_ready=1. Local writes are visible on the outputs and in read data from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous reset, active low |
| feat_page | input | 4 | write enable per page register (bit i for port 0x38+i) |
| feat_wide_sp | input | 1 | enables writes to the stack pointer high byte |
| req_valid | input | 1 | request present |
| req_port | input | 1 | 1: address is an I/O port number; 0: data address |
| req_we | input | 1 | 1 write, 0 read |
| req_addr | input | 16 | data address or port number |
| req_wdata | input | 8 | write byte |
| req_ready | output | 1 | request completes this cycle |
| req_rdata | output | 8 | read byte |
| mem_valid | output | 1 | external memory request |
| mem_we | output | 1 | external write |
| mem_addr | output | 16 | external byte address |
| mem_wdata | output | 8 | external write byte |
| mem_ready | input | 1 | external memory completes |
| mem_rdata | input | 8 | external read byte |
| sp_o | output | 16 | stack pointer |
| sreg_o | output | 8 | status register |
| page_o | output | 4x24 | page registers, pre-shifted |
| eind_o | output | 24 | extended jump register, pre-shifted |

## Verification
A wrong local register value is visible on sp_o, sreg_o, page_o or eind_o one cycle after the write that caused it. A wrong general register shows up only when the register is next read, and then in the same cycle as that read. A decode fault shows up at once in the cycle of the request, as a stray or missing mem_valid or a wrong mem_addr. The tests therefore sample directly after each write. They probe every boundary of the address windows (0x1F/0x20, 0x5F/0x60, and ports 0x37/0x38) with each feature input both set and clear.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

    typedef enum logic [1:0] {
        ZONE_GPR     = 2'd0,
        ZONE_SPECIAL = 2'd1,
        ZONE_MEM     = 2'd2
    } zone_e;

    // Index of a core-owned port inside the top eight ports of the I/O region.
    localparam logic [2:0] SUB_EIND = 3'd4;
    localparam logic [2:0] SUB_SPL  = 3'd5;
    localparam logic [2:0] SUB_SPH  = 3'd6;
    localparam logic [2:0] SUB_SREG = 3'd7;

    localparam int PAGE_N  = 4;
    localparam int WIDE_W  = 24;
    localparam int SHIFT_W = 16;

    typedef struct packed {
        logic [15:0]                   sp;
        logic [7:0]                    sreg;
        logic [WIDE_W-1:0]             eind;
        logic [PAGE_N-1:0][WIDE_W-1:0] page;
    } cpuio_t;

    function automatic logic [WIDE_W-1:0] to_wide(input logic [7:0] b);
        return {b, {SHIFT_W{1'b0}}};
    endfunction

endpackage

// File: rtl/dsr_decode.sv
module dsr_decode #(
    parameter int ADDR_W = 16,
    parameter int GPR_N  = 32,
    parameter int IO_N   = 64
) (
    input  logic                     port_mode,
    input  logic [ADDR_W-1:0]        addr,
    output dsr_pkg::zone_e           zone,
    output logic [$clog2(GPR_N)-1:0] gpr_idx,
    output logic [2:0]               sub,
    output logic [ADDR_W-1:0]        mem_addr
);
    import dsr_pkg::*;

    localparam int GPR_AW = $clog2(GPR_N);
    localparam int IO_AW  = $clog2(IO_N);
    localparam logic [ADDR_W-1:0] GPR_LIM  = ADDR_W'(GPR_N);
    localparam logic [ADDR_W-1:0] IO_LIM   = ADDR_W'(GPR_N + IO_N);
    localparam logic [ADDR_W-1:0] SPC_BASE = ADDR_W'(IO_N - 8);

    logic              in_gpr;
    logic              in_io;
    logic [ADDR_W-1:0] io_off;

    always_comb begin
        in_gpr  = !port_mode && (addr < GPR_LIM);
        in_io   = port_mode || (!in_gpr && (addr < IO_LIM));
        io_off  = port_mode ? ADDR_W'(addr[IO_AW-1:0]) : (addr - GPR_LIM);
        gpr_idx = addr[GPR_AW-1:0];
        sub     = io_off[2:0];
        if (in_gpr) begin
            zone     = ZONE_GPR;
            mem_addr = addr;
        end else if (in_io) begin
            zone     = (io_off >= SPC_BASE) ? ZONE_SPECIAL : ZONE_MEM;
            mem_addr = GPR_LIM + io_off;
        end else begin
            zone     = ZONE_MEM;
            mem_addr = addr;
        end
    end

endmodule

// File: rtl/dsr_gpr.sv
module dsr_gpr #(
    parameter int GPR_N = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(GPR_N)-1:0] idx,
    input  logic [7:0]               wdata,
    output logic [7:0]               rdata
);
    logic [7:0] gpr_d [GPR_N];
    logic [7:0] gpr_q [GPR_N];

    always_comb begin
        for (int i = 0; i < GPR_N; i++) begin
            gpr_d[i] = gpr_q[i];
            if (we && (idx == $bits(idx)'(i))) begin
                gpr_d[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < GPR_N; i++) begin
            if (!rst_n) begin
                gpr_q[i] <= 8'h00;
            end else begin
                gpr_q[i] <= gpr_d[i];
            end
        end
    end

    assign rdata = gpr_q[idx];

endmodule

// File: rtl/dsr_cpu_io.sv
module dsr_cpu_io #(
    parameter logic [15:0] SP_RESET = 16'h0000
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       we,
    input  logic [2:0]                                 sub,
    input  logic [7:0]                                 wdata,
    input  logic [dsr_pkg::PAGE_N-1:0]                 feat_page,
    input  logic                                       feat_wide_sp,
    output logic [7:0]                                 rdata,
    output logic [15:0]                                sp_o,
    output logic [7:0]                                 sreg_o,
    output logic [dsr_pkg::PAGE_N-1:0][dsr_pkg::WIDE_W-1:0] page_o,
    output logic [dsr_pkg::WIDE_W-1:0]                 eind_o
);
    import dsr_pkg::*;

    localparam cpuio_t RESET_ST = '{sp: SP_RESET, sreg: 8'h00, eind: '0, page: '0};

    cpuio_t            st_d;
    cpuio_t            st_q;
    logic [PAGE_N-1:0] page_we;

    for (genvar i = 0; i < PAGE_N; i++) begin : g_page
        assign page_we[i] = we && (sub == 3'(i)) && feat_page[i];
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < PAGE_N; i++) begin
            if (page_we[i]) begin
                st_d.page[i] = to_wide(wdata);
            end
        end
        if (we) begin
            case (sub)
                SUB_EIND: st_d.eind = to_wide(wdata);
                SUB_SPL:  st_d.sp[7:0] = wdata;
                SUB_SPH:  if (feat_wide_sp) st_d.sp[15:8] = wdata;
                SUB_SREG: st_d.sreg = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= RESET_ST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (sub)
            SUB_EIND: rdata = st_q.eind[WIDE_W-1:SHIFT_W];
            SUB_SPL:  rdata = st_q.sp[7:0];
            SUB_SPH:  rdata = st_q.sp[15:8];
            SUB_SREG: rdata = st_q.sreg;
            default:  rdata = st_q.page[sub[1:0]][WIDE_W-1:SHIFT_W];
        endcase
    end

    assign sp_o   = st_q.sp;
    assign sreg_o = st_q.sreg;
    assign page_o = st_q.page;
    assign eind_o = st_q.eind;

endmodule

// File: rtl/data_space_router.sv
module data_space_router #(
    parameter int          ADDR_W   = 16,
    parameter int          GPR_N    = 32,
    parameter int          IO_N     = 64,
    parameter logic [15:0] SP_RESET = 16'h0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       feat_page,
    input  logic             feat_wide_sp,
    input  logic             req_valid,
    input  logic             req_port,
    input  logic             req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]       req_wdata,
    output logic             req_ready,
    output logic [7:0]       req_rdata,
    output logic             mem_valid,
    output logic             mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]       mem_wdata,
    input  logic             mem_ready,
    input  logic [7:0]       mem_rdata,
    output logic [15:0]      sp_o,
    output logic [7:0]       sreg_o,
    output logic [3:0][23:0] page_o,
    output logic [23:0]      eind_o
);
    import dsr_pkg::*;

    localparam int GPR_AW = $clog2(GPR_N);

    zone_e             zone;
    logic [GPR_AW-1:0] gpr_idx;
    logic [2:0]        sub;
    logic [7:0]        gpr_rdata;
    logic [7:0]        io_rdata;
    logic              gpr_we;
    logic              io_we;

    dsr_decode #(.ADDR_W(ADDR_W), .GPR_N(GPR_N), .IO_N(IO_N)) u_decode (
        .port_mode (req_port),
        .addr      (req_addr),
        .zone      (zone),
        .gpr_idx   (gpr_idx),
        .sub       (sub),
        .mem_addr  (mem_addr)
    );

    assign gpr_we = req_valid && req_we && (zone == ZONE_GPR);
    assign io_we  = req_valid && req_we && (zone == ZONE_SPECIAL);

    dsr_gpr #(.GPR_N(GPR_N)) u_gpr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (gpr_we),
        .idx   (gpr_idx),
        .wdata (req_wdata),
        .rdata (gpr_rdata)
    );

    dsr_cpu_io #(.SP_RESET(SP_RESET)) u_cpu_io (
        .clk          (clk),
        .rst_n        (rst_n),
        .we           (io_we),
        .sub          (sub),
        .wdata        (req_wdata),
        .feat_page    (feat_page),
        .feat_wide_sp (feat_wide_sp),
        .rdata        (io_rdata),
        .sp_o         (sp_o),
        .sreg_o       (sreg_o),
        .page_o       (page_o),
        .eind_o       (eind_o)
    );

    always_comb begin
        mem_valid = req_valid && (zone == ZONE_MEM);
        mem_we    = req_we;
        mem_wdata = req_wdata;
        case (zone)
            ZONE_GPR: begin
                req_ready = 1'b1;
                req_rdata = gpr_rdata;
            end
            ZONE_SPECIAL: begin
                req_ready = 1'b1;
                req_rdata = io_rdata;
            end
            default: begin
                req_ready = mem_ready;
                req_rdata = mem_rdata;
            end
        endcase
    end

endmodule

// File: rtl/dsr_checker.sv
module dsr_checker #(
    parameter int ADDR_W = 16,
    parameter int GPR_N  = 32,
    parameter int IO_N   = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        feat_page,
    input logic              feat_wide_sp,
    input logic              req_valid,
    input logic              req_port,
    input logic              req_we,
    input logic [ADDR_W-1:0] req_addr,
    input logic [7:0]        req_wdata,
    input logic              req_ready,
    input logic              mem_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ready,
    input logic [15:0]       sp_o,
    input logic [3:0][23:0]  page_o,
    input logic [23:0]       eind_o
);
    localparam int IO_AW = $clog2(IO_N);

    logic              c_gpr;
    logic              c_hi;
    logic              c_io;
    logic              c_spc;
    logic [ADDR_W-1:0] c_off;
    logic              c_wr;

    always_comb begin
        c_gpr = !req_port && (int'(req_addr) < GPR_N);
        c_hi  = !req_port && (int'(req_addr) >= GPR_N + IO_N);
        c_io  = !c_gpr && !c_hi;
        c_off = req_port ? ADDR_W'(req_addr[IO_AW-1:0]) : ADDR_W'(int'(req_addr) - GPR_N);
        c_spc = c_io && (int'(c_off) >= IO_N - 8);
        c_wr  = req_valid && req_we && c_spc;
    end

    assert_gpr_local_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && c_gpr) |-> (!mem_valid && req_ready));

    assert_mem_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && c_hi) |-> (mem_valid && mem_addr == req_addr && req_ready == mem_ready));

    assert_io_forward_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && c_io && !c_spc) |-> (mem_valid && int'(mem_addr) == GPR_N + int'(c_off)));

    assert_low_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (page_o[0][15:0] | page_o[1][15:0] | page_o[2][15:0] | page_o[3][15:0]) == 16'h0);

    for (genvar i = 0; i < 4; i++) begin : g_gate
        assert_page_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (c_wr && c_off[2:0] == 3'(i) && !feat_page[i]) |=> $stable(page_o[i]));
    end

    assert_eind_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eind_o[15:0] == 16'h0);

    assert_spl_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr && c_off[2:0] == 3'd5) |=>
        (sp_o[15:8] == $past(sp_o[15:8]) && sp_o[7:0] == $past(req_wdata)));

    assert_sph_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr && c_off[2:0] == 3'd6 && !feat_wide_sp) |=> $stable(sp_o));

    assert_spc_local_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && c_spc) |-> (!mem_valid && req_ready));

endmodule

bind data_space_router dsr_checker #(.ADDR_W(ADDR_W), .GPR_N(GPR_N), .IO_N(IO_N)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .feat_page    (feat_page),
    .feat_wide_sp (feat_wide_sp),
    .req_valid    (req_valid),
    .req_port     (req_port),
    .req_we       (req_we),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .req_ready    (req_ready),
    .mem_valid    (mem_valid),
    .mem_addr     (mem_addr),
    .mem_ready    (mem_ready),
    .sp_o         (sp_o),
    .page_o       (page_o),
    .eind_o       (eind_o)
);

// File: tb/sim_data_space_router.sv
module sim_data_space_router;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [3:0]       feat_page = 4'h0;
    logic             feat_wide_sp = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_port = 1'b0;
    logic             req_we = 1'b0;
    logic [15:0]      req_addr = 16'h0;
    logic [7:0]       req_wdata = 8'h0;
    logic             req_ready;
    logic [7:0]       req_rdata;
    logic             mem_valid;
    logic             mem_we;
    logic [15:0]      mem_addr;
    logic [7:0]       mem_wdata;
    logic             mem_ready = 1'b1;
    logic [7:0]       mem_rdata;
    logic [15:0]      sp_o;
    logic [7:0]       sreg_o;
    logic [3:0][23:0] page_o;
    logic [23:0]      eind_o;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    // Samples taken during the last access
    logic        s_ready, s_mvalid, s_mwe;
    logic [7:0]  s_rdata, s_mwdata;
    logic [15:0] s_maddr;

    always #4 clk = ~clk;

    // External memory model: read data is a fixed function of the address
    assign mem_rdata = mem_addr[7:0] ^ 8'hC3;

    data_space_router u0 (
        .clk(clk), .rst_n(rst_n), .feat_page(feat_page), .feat_wide_sp(feat_wide_sp),
        .req_valid(req_valid), .req_port(req_port), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .req_rdata(req_rdata),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .sp_o(sp_o), .sreg_o(sreg_o),
        .page_o(page_o), .eind_o(eind_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One access: driven at a falling edge, sampled mid-cycle, committed at the rising edge
    task automatic access(input logic p, input logic we, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_port = p; req_we = we; req_addr = a; req_wdata = d;
        #1;
        s_ready = req_ready; s_rdata = req_rdata; s_mvalid = mem_valid;
        s_mwe = mem_we; s_maddr = mem_addr; s_mwdata = mem_wdata;
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
    endtask

    task automatic t_reset;
        chk("R11 sp", 32'(sp_o), 0);
        chk("R11 sreg", 32'(sreg_o), 0);
        chk("R11 page", 32'(page_o[0] | page_o[1] | page_o[2] | page_o[3]), 0);
        chk("R11 eind", 32'(eind_o), 0);
        access(1'b0, 1'b0, 16'h0007, 8'h00);
        chk("R11 gpr7", 32'(s_rdata), 0);
    endtask

    task automatic t_gpr;
        access(1'b0, 1'b1, 16'h0005, 8'h3C);
        chk("R1 write no mem", 32'(s_mvalid), 0);
        access(1'b0, 1'b1, 16'h001F, 8'h81);
        access(1'b0, 1'b0, 16'h0005, 8'h00);
        chk("R1 read gpr5", 32'(s_rdata), 32'h3C);
        chk("R1 ready", 32'(s_ready), 1);
        chk("R1 mem idle", 32'(s_mvalid), 0);
        access(1'b0, 1'b0, 16'h001F, 8'h00);
        chk("R1 read gpr31", 32'(s_rdata), 32'h81);
    endtask

    task automatic t_sreg;
        access(1'b0, 1'b1, 16'h005F, 8'h96);
        chk("R12 sreg write no mem", 32'(s_mvalid), 0);
        chk("R10 sreg via data address", 32'(sreg_o), 32'h96);
        access(1'b1, 1'b0, 16'h003F, 8'h00);
        chk("R2 R10 sreg via port", 32'(s_rdata), 32'h96);
        chk("R12 ready", 32'(s_ready), 1);
    endtask

    task automatic t_pages;
        feat_page = 4'b0101;
        access(1'b1, 1'b1, 16'h0038, 8'h12);
        access(1'b1, 1'b1, 16'h0039, 8'h34);
        access(1'b0, 1'b1, 16'h005A, 8'h56);
        access(1'b1, 1'b1, 16'h003B, 8'h78);
        chk("R5 page0", 32'(page_o[0]), 32'h120000);
        chk("R6 page1 gated", 32'(page_o[1]), 0);
        chk("R5 page2", 32'(page_o[2]), 32'h560000);
        chk("R6 page3 gated", 32'(page_o[3]), 0);
        access(1'b1, 1'b0, 16'h003A, 8'h00);
        chk("R5 page2 read", 32'(s_rdata), 32'h56);
        feat_page = 4'b1111;
        access(1'b1, 1'b1, 16'h0039, 8'h77);
        chk("R6 page1 enabled", 32'(page_o[1]), 32'h770000);
        feat_page = 4'b0000;
        access(1'b1, 1'b1, 16'h0038, 8'hEE);
        chk("R6 page0 held", 32'(page_o[0]), 32'h120000);
    endtask

    task automatic t_eind;
        access(1'b0, 1'b1, 16'h005C, 8'hAB);
        chk("R7 eind", 32'(eind_o), 32'hAB0000);
        access(1'b1, 1'b0, 16'h003C, 8'h00);
        chk("R7 eind read", 32'(s_rdata), 32'hAB);
    endtask

    task automatic t_sp;
        feat_wide_sp = 1'b0;
        access(1'b0, 1'b1, 16'h005D, 8'h44);
        chk("R8 spl", 32'(sp_o), 32'h0044);
        access(1'b1, 1'b1, 16'h003E, 8'h12);
        chk("R9 sph ignored", 32'(sp_o), 32'h0044);
        access(1'b1, 1'b0, 16'h003E, 8'h00);
        chk("R9 sph read", 32'(s_rdata), 0);
        feat_wide_sp = 1'b1;
        access(1'b1, 1'b1, 16'h003E, 8'h12);
        chk("R9 sph written", 32'(sp_o), 32'h1244);
        access(1'b1, 1'b1, 16'h003D, 8'h99);
        chk("R8 spl keeps high", 32'(sp_o), 32'h1299);
        access(1'b1, 1'b0, 16'h003D, 8'h00);
        chk("R8 spl read", 32'(s_rdata), 32'h99);
    endtask

    task automatic t_forward;
        mem_ready = 1'b1;
        access(1'b1, 1'b1, 16'h0010, 8'h5A);
        chk("R4 valid", 32'(s_mvalid), 1);
        chk("R4 addr", 32'(s_maddr), 32'h30);
        chk("R4 we", 32'(s_mwe), 1);
        chk("R4 wdata", 32'(s_mwdata), 32'h5A);
        access(1'b0, 1'b0, 16'h0057, 8'h00);
        chk("R4 edge port 0x37 addr", 32'(s_maddr), 32'h57);
        chk("R4 edge port 0x37 data", 32'(s_rdata), 32'h57 ^ 32'hC3);
        access(1'b0, 1'b0, 16'h0020, 8'h00);
        chk("R2 port0 via data addr", 32'(s_maddr), 32'h20);
        access(1'b1, 1'b0, 16'h0045, 8'h00);
        chk("R2 port mode uses low six bits", 32'(s_maddr), 32'h25);
    endtask

    task automatic t_mem;
        mem_ready = 1'b0;
        access(1'b0, 1'b0, 16'h0060, 8'h00);
        chk("R3 valid", 32'(s_mvalid), 1);
        chk("R3 stall", 32'(s_ready), 0);
        chk("R3 addr", 32'(s_maddr), 32'h60);
        mem_ready = 1'b1;
        access(1'b0, 1'b0, 16'h0060, 8'h00);
        chk("R3 ready", 32'(s_ready), 1);
        chk("R3 rdata", 32'(s_rdata), 32'h60 ^ 32'hC3);
        access(1'b0, 1'b1, 16'h1234, 8'hD2);
        chk("R3 write addr", 32'(s_maddr), 32'h1234);
        chk("R3 write data", 32'(s_mwdata), 32'hD2);
        access(1'b0, 1'b0, 16'h001F, 8'h00);
        chk("R1 boundary 0x1F local", 32'(s_mvalid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gpr();
        t_sreg();
        t_pages();
        t_eind();
        t_sp();
        t_forward();
        t_mem();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule